// File: doc/BRIEF.md
# Reference-Gated Clock Ratio Counter

This block counts how many cycles of a fast clock fit into a window set by a slow, accurate reference clock, for instance a 32.768 kHz crystal. Software or a trim engine compares the count against the nominal value and adjusts an internal oscillator. Everything runs on the fast clock. The reference is brought in through a synchronizer, and only its rising edges are used. A chosen number of those edges forms one measurement window.

The cycle count is held in a narrow wrapping counter and extended by an overflow counter, which together form a wide result. At the end of each window the result is latched, marked by a one-cycle valid pulse, and the next window starts on the same cycle. No cycle is dropped and none is counted twice.

When the fast clock is slow, close to twice the reference frequency, edges can slip past the detector. An option halves the reference before counting so that this does not happen.

Top module: `clkratio_meter`

## Requirements
- R1: While reset is held low, and on the first cycle after it is released, `result` is 0 and `result_vld` is 0.
- R2: The reference is sampled through a two-flop synchronizer, and only its rising edges are counted. A reference with period P fast cycles and a window of N edges therefore gives exactly N×P, not 2×N×P.
- R3: A window closes on the N-th counted rising edge after the previous close, where N is `win_len`. The latched result is the number of fast cycles between the two closing edges.
- R4: The cycle count is a CNT_W-bit counter (16 by default) plus an OVF_W-bit overflow counter, and result = 2^CNT_W × overflow + counter. A wrap on the same cycle as a capture is credited to the window that is closing. A window of exactly 2^CNT_W × k cycles reports 2^CNT_W × k.
- R5: Windows follow each other with no gap. Every result in an unbroken run equals N×P, and both counters read zero on the cycle after a capture.
- R6: `result_vld` is high for exactly one cycle per capture. `result` changes only on that cycle and holds its value until the next capture.
- R7: The first window after reset or after `meas_en` rises is discarded with no valid pulse. The first valid arrives no earlier than (2N−1)×P cycles after enabling.
- R8: A new `win_len` value is taken only when a window starts. A change made partway through a window leaves that window at its old length and applies to the window after it.
- R9: With `ref_div2` = 1, only every second rising edge is counted, so each counted edge spans two reference periods and the result is N×2P.
- R10: While `meas_en` is 0, no valid pulse occurs, `result` holds its value and the counters stay cleared.
- R11: A `win_len` of 0 behaves as 1, so every counted edge closes a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Clock under test; all logic runs on it |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Slow reference clock, asynchronous to clk_fast |
| meas_en | input | 1 | Runs measurement while high; clears counters while low |
| win_len | input | WIN_W | Window length in counted reference edges |
| ref_div2 | input | 1 | 1 = count every second reference rising edge |
| result | output | CNT_W+OVF_W | Fast cycles in the last completed window |
| result_vld | output | 1 | One-cycle pulse when result is updated |

## Verification
The assertions check on every cycle that the valid pulse lasts one cycle, that the result does not move between pulses, that nothing is reported while disabled or for the first window after enabling, that a counter wrap without a capture raises the overflow count by one, and that a capture leaves both counters at zero. The numeric accuracy of the count can only be shown by the bench's scenarios. These are exact products of window length and reference period, including windows that end exactly on a counter wrap, halved-reference runs, a length change partway through a window, and a zero window length.

// File: rtl/clkratio_pkg.sv
// Package: shared defaults and the reference edge mode for the clock ratio counter.
// Assumes: nothing; holds only constants and types.
package clkratio_pkg;

    // Default widths of the measurement datapath
    localparam int unsigned DEF_CNT_W  = 16;
    localparam int unsigned DEF_OVF_W  = 16;
    localparam int unsigned DEF_WIN_W  = 16;
    localparam int unsigned DEF_SYNC_N = 2;

    // Which reference rising edges are counted
    typedef enum logic {
        REF_EVERY_EDGE = 1'b0,
        REF_HALVED     = 1'b1
    } ref_mode_e;

endpackage

// File: rtl/clkratio_ref_edge.sv
// Module: brings the asynchronous reference into the fast domain and emits a
// one-cycle pulse per counted rising edge. In REF_HALVED mode only every
// second rising edge produces a pulse.
// Assumes: SYNC_N >= 2; pulses are at least two cycles apart by construction.
module clkratio_ref_edge
    import clkratio_pkg::*;
#(
    parameter int unsigned SYNC_N = DEF_SYNC_N
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ref_async,
    input  logic      clr,
    input  ref_mode_e mode,
    output logic      edge_pulse
);

    localparam int unsigned TOP = SYNC_N - 1;

    logic [SYNC_N-1:0] sync_q;
    logic              ref_prev_q;
    logic              phase_q;
    logic              raw_rise;

    // Synchronizer chain: shifts the reference in, oldest sample at TOP
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[TOP-1:0], ref_async};
    end

    // Previous synchronized level, for rising-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) ref_prev_q <= 1'b0;
        else        ref_prev_q <= sync_q[TOP];
    end

    assign raw_rise = sync_q[TOP] & ~ref_prev_q;

    // Halving phase: toggles on every raw rising edge, cleared when idle
    always_ff @(posedge clk) begin
        if (!rst_n || clr) phase_q <= 1'b0;
        else if (raw_rise) phase_q <= ~phase_q;
    end

    // Select every edge or every second edge
    always_comb begin
        if (mode == REF_HALVED) edge_pulse = raw_rise & phase_q;
        else                    edge_pulse = raw_rise;
    end

endmodule

// File: rtl/clkratio_window.sv
// Module: counts edge pulses and flags the pulse that closes a window.
// The window length is sampled only when a window begins.
// Assumes: a latched length of 0 acts as 1.
module clkratio_window #(
    parameter int unsigned WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             edge_pulse,
    input  logic [WIN_W-1:0] win_len,
    output logic             win_end
);

    logic [WIN_W-1:0] edge_cnt_q;
    logic [WIN_W-1:0] len_q;
    logic [WIN_W:0]   edge_inc;

    assign edge_inc = {1'b0, edge_cnt_q} + 1'b1;
    assign win_end  = run & edge_pulse & (edge_inc >= {1'b0, len_q});

    // Edge count within the window and the length in force for it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cnt_q <= '0;
            len_q      <= '0;
        end else if (!run || win_end) begin
            edge_cnt_q <= '0;
            len_q      <= win_len;
        end else if (edge_pulse) begin
            edge_cnt_q <= edge_inc[WIN_W-1:0];
        end
    end

endmodule

// File: rtl/clkratio_accum.sv
// Module: fast-cycle accumulator made of a CNT_W-bit wrapping counter and an
// OVF_W-bit overflow counter. The snapshot includes the current cycle and its
// carry, so a wrap on the capture cycle belongs to the closing window.
// Assumes: capture clears both counters for the next window.
module clkratio_accum #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned OVF_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run,
    input  logic                   capture,
    output logic [CNT_W+OVF_W-1:0] snapshot,
    output logic [CNT_W-1:0]       cnt_q,
    output logic [OVF_W-1:0]       ovf_q
);

    logic [CNT_W-1:0] cnt_inc;
    logic             carry;
    logic [OVF_W-1:0] ovf_inc;

    assign {carry, cnt_inc} = {1'b0, cnt_q} + 1'b1;
    assign ovf_inc          = ovf_q + {{(OVF_W-1){1'b0}}, carry};
    assign snapshot         = {ovf_inc, cnt_inc};

    // Count cycles while running; restart from zero after a capture
    always_ff @(posedge clk) begin
        if (!rst_n || !run || capture) begin
            cnt_q <= '0;
            ovf_q <= '0;
        end else begin
            cnt_q <= cnt_inc;
            ovf_q <= ovf_inc;
        end
    end

endmodule

// File: rtl/clkratio_meter.sv
// Module: top of the reference-gated clock ratio counter. It ties the edge
// detector, window counter and accumulator together, drops the first window
// after enable, and latches each later result with a one-cycle valid.
// Assumes: ref_div2 is static while meas_en is high.
module clkratio_meter
    import clkratio_pkg::*;
#(
    parameter int unsigned CNT_W       = DEF_CNT_W,
    parameter int unsigned OVF_W       = DEF_OVF_W,
    parameter int unsigned WIN_W       = DEF_WIN_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_N
) (
    input  logic                   clk_fast,
    input  logic                   rst_n,
    input  logic                   ref_in,
    input  logic                   meas_en,
    input  logic [WIN_W-1:0]       win_len,
    input  logic                   ref_div2,
    output logic [CNT_W+OVF_W-1:0] result,
    output logic                   result_vld
);

    localparam int unsigned RES_W = CNT_W + OVF_W;

    logic             edge_pulse;
    logic             win_end;
    logic [RES_W-1:0] snapshot;
    logic [CNT_W-1:0] acc_cnt;
    logic [OVF_W-1:0] acc_ovf;
    logic             first_q;
    ref_mode_e        ref_mode;

    assign ref_mode = ref_mode_e'(ref_div2);

    clkratio_ref_edge #(.SYNC_N(SYNC_STAGES)) u_edge (
        .clk        (clk_fast),
        .rst_n      (rst_n),
        .ref_async  (ref_in),
        .clr        (~meas_en),
        .mode       (ref_mode),
        .edge_pulse (edge_pulse)
    );

    clkratio_window #(.WIN_W(WIN_W)) u_win (
        .clk        (clk_fast),
        .rst_n      (rst_n),
        .run        (meas_en),
        .edge_pulse (edge_pulse),
        .win_len    (win_len),
        .win_end    (win_end)
    );

    clkratio_accum #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_acc (
        .clk      (clk_fast),
        .rst_n    (rst_n),
        .run      (meas_en),
        .capture  (win_end),
        .snapshot (snapshot),
        .cnt_q    (acc_cnt),
        .ovf_q    (acc_ovf)
    );

    // First-window flag: set while idle, cleared by the first capture
    always_ff @(posedge clk_fast) begin
        if (!rst_n || !meas_en) first_q <= 1'b1;
        else if (win_end)       first_q <= 1'b0;
    end

    // Result register and valid pulse for every capture after the first
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            result     <= '0;
            result_vld <= 1'b0;
        end else begin
            result_vld <= win_end & ~first_q;
            if (win_end && !first_q) result <= snapshot;
        end
    end

endmodule

// File: rtl/clkratio_meter_chk.sv
// Module: property checker for clkratio_meter, attached with bind below.
// Assumes: synchronous active-low reset held for at least two clock edges.
module clkratio_meter_chk #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned OVF_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   meas_en,
    input logic [CNT_W+OVF_W-1:0] result,
    input logic                   result_vld,
    input logic                   win_end,
    input logic [CNT_W-1:0]       acc_cnt,
    input logic [OVF_W-1:0]       acc_ovf
);

    logic [1:0] caps_seen;

    // Captures seen since enable, saturating at two
    always_ff @(posedge clk) begin
        if (!rst_n || !meas_en)             caps_seen <= 2'd0;
        else if (win_end && caps_seen != 2'd2) caps_seen <= caps_seen + 2'd1;
    end

    AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) result_vld |=> !result_vld); // R6
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n) !result_vld |-> $stable(result)); // R6
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n) !meas_en |=> !result_vld); // R10
    AST_FIRST_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) result_vld |-> caps_seen == 2'd2); // R7
    AST_WRAP_CARRIES: assert property (@(posedge clk) disable iff (!rst_n) (meas_en && !win_end && acc_cnt == {CNT_W{1'b1}}) |=> acc_ovf == OVF_W'($past(acc_ovf) + 1'b1)); // R4
    AST_CAPTURE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) win_end |=> (acc_cnt == '0 && acc_ovf == '0)); // R5

endmodule

bind clkratio_meter clkratio_meter_chk #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_chk (
    .clk        (clk_fast),
    .rst_n      (rst_n),
    .meas_en    (meas_en),
    .result     (result),
    .result_vld (result_vld),
    .win_end    (win_end),
    .acc_cnt    (acc_cnt),
    .acc_ovf    (acc_ovf)
);

// File: tb/clkratio_meter_test.sv
// Bench: directed scenarios for clkratio_meter. The reference is generated from
// the fast clock, so every window has an exact expected cycle count.
module clkratio_meter_test;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 8;
    localparam int OVF_W = 24;
    localparam int WIN_W = 16;

    logic             clk_fast = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_in = 1'b0;
    logic             meas_en = 1'b0;
    logic [WIN_W-1:0] win_len = '0;
    logic             ref_div2 = 1'b0;
    logic [31:0]      result;
    logic             result_vld;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int ref_half = 4;
    int rgen_cnt = 0;
    int vld_count = 0;
    int long_pulses = 0;
    logic prev_vld = 1'b0;
    logic [31:0] res_log [0:63];
    int          vld_cyc [0:63];

    clkratio_meter #(.CNT_W(CNT_W), .OVF_W(OVF_W), .WIN_W(WIN_W), .SYNC_STAGES(2)) uut (
        .clk_fast   (clk_fast),
        .rst_n      (rst_n),
        .ref_in     (ref_in),
        .meas_en    (meas_en),
        .win_len    (win_len),
        .ref_div2   (ref_div2),
        .result     (result),
        .result_vld (result_vld)
    );

    always #(CLK_PERIOD/2) clk_fast = ~clk_fast;

    always @(posedge clk_fast) cyc <= cyc + 1;

    // Reference generator: toggles every ref_half fast cycles, away from posedge
    always @(negedge clk_fast) begin
        if (rgen_cnt + 1 >= ref_half) begin
            ref_in   <= ~ref_in;
            rgen_cnt <= 0;
        end else begin
            rgen_cnt <= rgen_cnt + 1;
        end
    end

    // Monitor: logs every valid result and counts pulses longer than a cycle
    always @(negedge clk_fast) begin
        if (result_vld && prev_vld) long_pulses = long_pulses + 1;
        if (result_vld && vld_count < 64) begin
            res_log[vld_count] = result;
            vld_cyc[vld_count] = cyc;
        end
        if (result_vld) vld_count = vld_count + 1;
        prev_vld = result_vld;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_vld(input int idx);
        while (vld_count <= idx) @(negedge clk_fast);
    endtask

    // Configure, enable, and check `count` results plus first-window timing
    task automatic measure(input int half, input int n, input bit div2, input int count, input string tag);
        int p_eff;
        int n_eff;
        int base;
        int t0;
        meas_en = 1'b0;
        @(negedge clk_fast);
        ref_half = half;
        win_len  = WIN_W'(n);
        ref_div2 = div2;
        repeat (140) @(negedge clk_fast);
        p_eff = div2 ? 4 * half : 2 * half;
        n_eff = (n == 0) ? 1 : n;
        base  = vld_count;
        t0    = cyc;
        meas_en = 1'b1;
        for (int i = 0; i < count; i++) begin
            wait_vld(base + i);
            check(res_log[base + i] == 32'(n_eff * p_eff), tag, res_log[base + i], n_eff * p_eff);
        end
        check(vld_cyc[base] - t0 >= (2 * n_eff - 1) * p_eff, "R7 first window dropped",
              vld_cyc[base] - t0, (2 * n_eff - 1) * p_eff);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk_fast);
        check(result == 0, "R1 result in reset", result, 0);
        check(result_vld == 0, "R1 valid in reset", result_vld, 0);
        rst_n = 1'b1;
        @(negedge clk_fast);
        check(result == 0 && result_vld == 0, "R1 after release", result, 0);
    endtask

    task automatic t_basic();
        logic [31:0] held;
        measure(4, 4, 1'b0, 3, "R3 R5 R2 basic window");
        held = result;
        repeat (5) @(negedge clk_fast);
        check(result == held, "R6 result held", result, held);
    endtask

    task automatic t_wrap();
        measure(32, 4, 1'b0, 2, "R4 wrap on capture 256");
        measure(16, 16, 1'b0, 2, "R4 wrap on capture 512");
        measure(25, 10, 1'b0, 2, "R4 unaligned 500");
        measure(64, 6, 1'b0, 2, "R4 R5 three wraps 768");
    endtask

    task automatic t_div2();
        measure(3, 3, 1'b1, 2, "R9 halved ref 36");
        measure(1, 5, 1'b1, 2, "R9 halved fast ref 20");
    endtask

    task automatic t_wlen();
        int base;
        meas_en = 1'b0;
        @(negedge clk_fast);
        ref_half = 5;
        win_len  = WIN_W'(4);
        ref_div2 = 1'b0;
        repeat (140) @(negedge clk_fast);
        base = vld_count;
        meas_en = 1'b1;
        wait_vld(base);
        win_len = WIN_W'(2);
        wait_vld(base + 2);
        check(res_log[base + 1] == 40, "R8 old length kept", res_log[base + 1], 40);
        check(res_log[base + 2] == 20, "R8 new length next window", res_log[base + 2], 20);
    endtask

    task automatic t_zero();
        measure(6, 0, 1'b0, 2, "R11 zero length acts as one");
    endtask

    task automatic t_disable();
        int vc;
        logic [31:0] held;
        meas_en = 1'b0;
        @(negedge clk_fast);
        vc   = vld_count;
        held = result;
        repeat (80) @(negedge clk_fast);
        check(vld_count == vc, "R10 no valid while disabled", vld_count, vc);
        check(result == held, "R10 result held while disabled", result, held);
        measure(4, 3, 1'b0, 1, "R10 R7 re-enable");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_wrap();
        t_div2();
        t_wlen();
        t_zero();
        t_disable();
        check(long_pulses == 0, "R6 valid is one cycle", long_pulses, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule